// File: doc/BRIEF.md
# Line-Rate NMI Pulse Generator

This block times a horizontal-line pulse train for a small video controller attached to a Z80-class CPU. It takes the fast system clock and divides it by two to make the CPU clock. It provides that clock in both true and inverted phases. The halved clock drives a line counter built from two cascaded synchronous stages. The low stage counts 16 ticks, and the high stage advances on the low stage's carry. Together they give a line of 208 CPU-clock ticks. In the last slot of each line the block drives an active-low horizontal sync pulse that is 16 ticks wide.

The same pulse can also drive the CPU's active-low non-maskable interrupt line. Software controls this with I/O writes. A write with address bit 0 low turns interrupt generation on. A write with address bit 1 low turns it off. A new setting is captured only when the line counter wraps. Because of this, an interrupt pulse always matches the full sync pulse, and no shortened pulse can reach the CPU.

Top module: `lrn_nmi_gen`

## Requirements
- R1: While `rst` is high and after it is released, `hsync_n` and `nmi_n` are high and interrupt generation is off.
- R2: `cpu_clk` toggles on every `clk` cycle, and `cpu_clk_n` is always its complement.
- R3: Successive falling edges of `hsync_n` are 416 `clk` cycles (208 ticks) apart.
- R4: Each `hsync_n` pulse stays low for exactly 32 `clk` cycles (16 ticks).
- R5: A cycle with `iorq_n` and `wr_n` both low, `a0` low and `a1` high sets the generation flag.
- R6: A cycle with `iorq_n` and `wr_n` both low and `a1` low clears the flag. This includes the case where `a0` is also low, because clearing takes priority.
- R7: A cycle in which `iorq_n` or `wr_n` is high leaves the flag unchanged, and so does a write with both `a0` and `a1` high.
- R8: While generation is off, `nmi_n` stays high and `hsync_n` keeps its full period and width.
- R9: While generation is on, `nmi_n` is low in exactly the cycles in which `hsync_n` is low. `nmi_n` is never low while `hsync_n` is high.
- R10: A flag change takes effect only at the next line wrap. A pulse already in progress is neither shortened nor started late, and the pulse just before the wrap still follows the old setting.
- R11: After reset is released, the first `hsync_n` falling edge appears at the 385th `clk` rising edge. This corresponds to line count 192.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock (twice the CPU rate) |
| rst | input | 1 | Synchronous reset, active high |
| iorq_n | input | 1 | CPU I/O request strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| a0 | input | 1 | Address bit 0; low selects the enable port |
| a1 | input | 1 | Address bit 1; low selects the disable port |
| cpu_clk | output | 1 | Halved clock, true phase |
| cpu_clk_n | output | 1 | Halved clock, inverted phase |
| hsync_n | output | 1 | Horizontal sync pulse, active low |
| nmi_n | output | 1 | Non-maskable interrupt, active low |

## Verification
The hardest case to reach is a flag write that lands inside a sync pulse. The pulse must keep its old interrupt state to the end, and the new state must apply from the pulse after the next line wrap. The bench waits for a falling edge of `hsync_n` and issues the write a few cycles into the pulse, once to switch generation on and once to switch it off. It then counts the `nmi_n` low cycles in that pulse and in the following one. For the table-driven port writes, the bench skips the pulse right after each write and checks that this pulse still shows the old setting.

// File: rtl/lrn_pkg.sv
package lrn_pkg;

    // Low stage modulus: ticks per sync slot (sets the pulse width).
    localparam int unsigned LO_MOD  = 16;
    // High stage modulus: slots per line (208 ticks total).
    localparam int unsigned HI_MOD  = 13;
    // High-stage value during which sync is driven.
    localparam int unsigned SYNC_HI = 12;

    localparam int unsigned LO_W = (LO_MOD > 1) ? $clog2(LO_MOD) : 1;
    localparam int unsigned HI_W = (HI_MOD > 1) ? $clog2(HI_MOD) : 1;

    // Decoded CPU port-write command.
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_ON   = 2'd1,
        CMD_OFF  = 2'd2
    } port_cmd_e;

    typedef struct packed {
        logic ph;
    } phase_st_t;

    typedef struct packed {
        logic en;
    } gate_st_t;

    typedef struct packed {
        logic arm;
        logic hs;
        logic nmi;
    } pulse_st_t;

endpackage

// File: rtl/lrn_phase.sv
module lrn_phase (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic cpu_clk,
    output logic cpu_clk_n
);
    import lrn_pkg::*;

    phase_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = ~st_q.ph;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // Counter advances on the clk edge that ends the high half of cpu_clk.
    assign tick      = st_q.ph;
    assign cpu_clk   = st_q.ph;
    assign cpu_clk_n = ~st_q.ph;

endmodule

// File: rtl/lrn_cnt_stage.sv
module lrn_cnt_stage #(
    parameter int unsigned MOD = 16,
    localparam int unsigned W  = (MOD > 1) ? $clog2(MOD) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    output logic [W-1:0] cnt,
    output logic         carry
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    typedef struct packed {
        logic [W-1:0] val;
    } stage_st_t;

    stage_st_t st_d, st_q;
    logic      at_last;

    always_comb begin
        at_last = (st_q.val == LAST);
        st_d    = st_q;
        if (ce) begin
            if (at_last) st_d.val = '0;
            else         st_d.val = st_q.val + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt   = st_q.val;
    assign carry = ce & at_last;

endmodule

// File: rtl/lrn_port_dec.sv
module lrn_port_dec (
    input  logic clk,
    input  logic rst,
    input  logic iorq_n,
    input  logic wr_n,
    input  logic a0,
    input  logic a1,
    output logic gen_en
);
    import lrn_pkg::*;

    gate_st_t  st_d, st_q;
    port_cmd_e cmd;

    always_comb begin
        cmd = CMD_NONE;
        if (!iorq_n && !wr_n) begin
            if (!a1)      cmd = CMD_OFF;   // disable port wins
            else if (!a0) cmd = CMD_ON;
        end

        st_d = st_q;
        unique case (cmd)
            CMD_ON:  st_d.en = 1'b1;
            CMD_OFF: st_d.en = 1'b0;
            default: st_d.en = st_q.en;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign gen_en = st_q.en;

endmodule

// File: rtl/lrn_pulse.sv
module lrn_pulse #(
    parameter int unsigned HI_W    = 4,
    parameter int unsigned SYNC_HI = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [HI_W-1:0] hi_cnt,
    input  logic            line_wrap,
    input  logic            gen_en,
    output logic            hsync_n,
    output logic            nmi_n
);
    import lrn_pkg::*;

    localparam logic [HI_W-1:0] SLOT = HI_W'(SYNC_HI);

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // Generation flag is sampled only at the line boundary.
        st_d.arm = line_wrap ? gen_en : st_q.arm;
        st_d.hs  = (hi_cnt == SLOT);
        st_d.nmi = st_d.hs & st_q.arm;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hsync_n = ~st_q.hs;
    assign nmi_n   = ~st_q.nmi;

endmodule

// File: rtl/lrn_nmi_gen.sv
module lrn_nmi_gen (
    input  logic clk,
    input  logic rst,
    input  logic iorq_n,
    input  logic wr_n,
    input  logic a0,
    input  logic a1,
    output logic cpu_clk,
    output logic cpu_clk_n,
    output logic hsync_n,
    output logic nmi_n
);
    import lrn_pkg::*;

    logic            tick;
    logic [LO_W-1:0] lo_cnt;
    logic [HI_W-1:0] hi_cnt;
    logic            lo_carry;
    logic            line_wrap;
    logic            gen_en;

    lrn_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cpu_clk   (cpu_clk),
        .cpu_clk_n (cpu_clk_n)
    );

    lrn_cnt_stage #(.MOD(LO_MOD)) u_lo (
        .clk   (clk),
        .rst   (rst),
        .ce    (tick),
        .cnt   (lo_cnt),
        .carry (lo_carry)
    );

    lrn_cnt_stage #(.MOD(HI_MOD)) u_hi (
        .clk   (clk),
        .rst   (rst),
        .ce    (lo_carry),
        .cnt   (hi_cnt),
        .carry (line_wrap)
    );

    lrn_port_dec u_dec (
        .clk    (clk),
        .rst    (rst),
        .iorq_n (iorq_n),
        .wr_n   (wr_n),
        .a0     (a0),
        .a1     (a1),
        .gen_en (gen_en)
    );

    lrn_pulse #(.HI_W(HI_W), .SYNC_HI(SYNC_HI)) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .hi_cnt    (hi_cnt),
        .line_wrap (line_wrap),
        .gen_en    (gen_en),
        .hsync_n   (hsync_n),
        .nmi_n     (nmi_n)
    );

    logic unused_lo;
    assign unused_lo = ^lo_cnt;

endmodule

// File: rtl/lrn_nmi_gen_chk.sv
module lrn_nmi_gen_chk (
    input logic clk,
    input logic rst,
    input logic iorq_n,
    input logic wr_n,
    input logic a0,
    input logic a1,
    input logic cpu_clk,
    input logic cpu_clk_n,
    input logic hsync_n,
    input logic nmi_n,
    input logic gen_en
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (hsync_n && nmi_n && !gen_en));

    p_phase_comp_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_n == !cpu_clk);

    p_phase_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cpu_clk != $past(cpu_clk)));

    p_port_on_r5: assert property (@(posedge clk) disable iff (rst)
        (!iorq_n && !wr_n && !a0 && a1) |=> gen_en);

    p_port_off_r6: assert property (@(posedge clk) disable iff (rst)
        (!iorq_n && !wr_n && !a1) |=> !gen_en);

    p_port_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (iorq_n || wr_n || (a0 && a1)) |=> $stable(gen_en));

    p_nmi_in_sync_r9: assert property (@(posedge clk) disable iff (rst)
        !nmi_n |-> !hsync_n);

    p_nmi_start_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(nmi_n) |-> $fell(hsync_n));

    p_nmi_end_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_n) |-> $rose(hsync_n));

endmodule

bind lrn_nmi_gen lrn_nmi_gen_chk u_chk (.*);

// File: tb/lrn_nmi_gen_test.sv
module lrn_nmi_gen_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic iorq_n = 1'b1, wr_n = 1'b1, a0 = 1'b1, a1 = 1'b1;
    logic cpu_clk, cpu_clk_n, hsync_n, nmi_n;

    int checks = 0;
    int fails = 0;
    int stray = 0;
    int cyc = 0;
    logic wd = 1'b0;

    localparam int PERIOD = 416;
    localparam int WIDTH  = 32;
    localparam int FIRST  = 385;

    // Vector bits: {iorq_n, wr_n, a0, a1, flag expected afterwards}
    localparam logic [4:0] VEC [7] = '{
        5'b00011,   // R5 enable
        5'b01101,   // R7 wr_n high, a1 low: hold on
        5'b00111,   // R7 no address bit low: hold on
        5'b00100,   // R6 disable
        5'b10010,   // R7 iorq_n high: hold off
        5'b00011,   // R5 enable again
        5'b00000    // R6 both low: disable wins
    };

    always #2 clk = ~clk;

    lrn_nmi_gen uut (
        .clk(clk), .rst(rst), .iorq_n(iorq_n), .wr_n(wr_n), .a0(a0), .a1(a1),
        .cpu_clk(cpu_clk), .cpu_clk_n(cpu_clk_n), .hsync_n(hsync_n), .nmi_n(nmi_n)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst && !nmi_n && hsync_n) stray <= stray + 1;
        if (cyc > 150000) wd <= 1'b1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_fall(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (hsync_n != 1'b0 && !wd);
    endtask

    // Starts at a negedge with hsync_n low; returns at the negedge where it is high.
    task automatic measure(input int inj, input logic ia0, input logic ia1,
                           output int hw, output int nw);
        hw = 0;
        nw = 0;
        while (hsync_n == 1'b0 && !wd) begin
            hw++;
            if (!nmi_n) nw++;
            if (hw == inj) {iorq_n, wr_n, a0, a1} = {1'b0, 1'b0, ia0, ia1};
            else           {iorq_n, wr_n, a0, a1} = 4'b1111;
            @(negedge clk);
        end
        {iorq_n, wr_n, a0, a1} = 4'b1111;
    endtask

    task automatic port(input logic [3:0] s);
        {iorq_n, wr_n, a0, a1} = s;
        @(negedge clk);
        {iorq_n, wr_n, a0, a1} = 4'b1111;
    endtask

    initial begin : main
        int n, hw, nw, p0, p1;
        logic prev;

        repeat (4) @(negedge clk);
        chk("R1 hsync_n in reset", int'(hsync_n), 1);
        chk("R1 nmi_n in reset", int'(nmi_n), 1);
        rst = 1'b0;

        @(negedge clk);
        p0 = int'(cpu_clk);
        chk("R2 complement", int'(cpu_clk_n), int'(!cpu_clk));
        @(negedge clk);
        p1 = int'(cpu_clk);
        chk("R2 toggle", p1, int'(!p0[0]));
        chk("R2 complement", int'(cpu_clk_n), int'(!cpu_clk));

        wait_fall(n);
        chk("R11 first fall", n + 2, FIRST);
        measure(-1, 1'b1, 1'b1, hw, nw);
        chk("R4 width", hw, WIDTH);
        chk("R1 R8 nmi off after reset", nw, 0);
        wait_fall(n);
        chk("R3 period", n + hw, PERIOD);
        measure(-1, 1'b1, 1'b1, hw, nw);
        chk("R8 hsync width while off", hw, WIDTH);
        chk("R8 nmi quiet while off", nw, 0);

        // Table walk: write just after a pulse, skip one pulse, then inspect.
        prev = 1'b0;
        for (int i = 0; i < 7; i++) begin
            port(VEC[i][4:1]);
            wait_fall(n);
            measure(-1, 1'b1, 1'b1, hw, nw);
            chk("R10 old setting before wrap", nw, prev ? WIDTH : 0);
            wait_fall(n);
            measure(-1, 1'b1, 1'b1, hw, nw);
            chk("R4 width", hw, WIDTH);
            chk("R5 R6 R7 R9 nmi after write", nw, VEC[i][0] ? WIDTH : 0);
            prev = VEC[i][0];
        end

        // Mid-pulse enable while off (R10).
        wait_fall(n);
        measure(5, 1'b0, 1'b1, hw, nw);
        chk("R10 mid-pulse on keeps pulse", nw, 0);
        chk("R4 width with write", hw, WIDTH);
        wait_fall(n);
        measure(-1, 1'b1, 1'b1, hw, nw);
        chk("R10 on after wrap", nw, WIDTH);

        // Mid-pulse disable while on (R10).
        wait_fall(n);
        measure(7, 1'b1, 1'b0, hw, nw);
        chk("R10 mid-pulse off keeps pulse", nw, WIDTH);
        wait_fall(n);
        measure(-1, 1'b1, 1'b1, hw, nw);
        chk("R10 off after wrap", nw, 0);

        // Reset while generation is on (R1).
        port(4'b0001);
        wait_fall(n);
        measure(-1, 1'b1, 1'b1, hw, nw);
        wait_fall(n);
        measure(-1, 1'b1, 1'b1, hw, nw);
        chk("R9 enabled before reset", nw, WIDTH);
        repeat (10) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 hsync_n in reset", int'(hsync_n), 1);
        chk("R1 nmi_n in reset", int'(nmi_n), 1);
        rst = 1'b0;
        wait_fall(n);
        chk("R11 first fall after reset", n, FIRST);
        measure(-1, 1'b1, 1'b1, hw, nw);
        chk("R1 flag cleared", nw, 0);
        wait_fall(n);
        measure(-1, 1'b1, 1'b1, hw, nw);
        chk("R1 flag cleared next line", nw, 0);

        chk("R9 nmi never outside sync", stray, 0);
        if (wd) chk("watchdog", 1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule